// File: doc/BRIEF.md
# Edge-Triggered Sample-and-Hold Register

This block keeps a vector of `ELEMS` elements, each `ELEM_W` bits wide, on its output and replaces the whole vector only when a selected event appears on a one-bit trigger. The trigger is sampled once per clock, the same rate as the data. Events are found by comparing the trigger with the copy of it taken one clock earlier. A two-bit run-time select picks the event: rising edge, falling edge, either edge, or none.

Until the first event, the output carries an initial-condition vector. A parameter gives this vector per element, or gives one scalar that is copied into every element. A run-time previous-cycle mode makes a capture take the data word from one clock earlier instead of the current one. This removes every combinational path from `data_i` to the capture, so the block can sit inside a feedback loop.

A two-state controller tracks whether a capture has taken place. `ST_INIT` shows the initial condition. The transition `first_capture` leads to `ST_HELD` on the first event. In `ST_HELD`, the `recapture` self-loop is taken on each later event. Without an event, `wait` keeps either state.

Top module: `sample_hold_reg`

## Requirements
- R1: While `rst_n` is low, the block is in `ST_INIT`, `hold_o` equals the initial-condition vector, the stored previous trigger is 0 and the stored previous data word is 0.
- R2: With `INIT_BY_ELEM`=1, the initial condition is `INIT_VEC`, with element e in bits [e*ELEM_W +: ELEM_W]. With `INIT_BY_ELEM`=0, every element holds `INIT_SCALAR`. `hold_o` shows this value until the first event.
- R3: With `edge_sel_i`=2'b00, an event occurs when `trig_i` is 1 and the previous trigger sample is 0.
- R4: With `edge_sel_i`=2'b01, an event occurs when `trig_i` is 0 and the previous trigger sample is 1.
- R5: With `edge_sel_i`=2'b10, an event occurs when `trig_i` differs from the previous trigger sample.
- R6: With `edge_sel_i`=2'b11, no event ever occurs.
- R7: In a cycle without an event, `hold_o` keeps its value, whatever `data_i` and `prev_mode_i` do.
- R8: With `prev_mode_i`=0, an event sampled at a clock edge loads every element with the `data_i` present at that edge. The new value appears on `hold_o` right after that edge.
- R9: With `prev_mode_i`=1, an event loads `data_i` as sampled at the preceding clock edge. On the first cycle after reset, this value is 0.
- R10: On the first clock after reset, the previous trigger sample counts as 0. A trigger held high through reset therefore gives a rising event, and a trigger held low gives no falling event.
- R11: The previous trigger sample updates on every clock whatever `edge_sel_i` is. Changing `edge_sel_i` while the trigger is steady creates no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger sample, one per clock |
| edge_sel_i | input | 2 | Event select: 00 rising, 01 falling, 10 either, 11 none |
| prev_mode_i | input | 1 | 1 = capture the previous cycle's data word |
| data_i | input | ELEMS*ELEM_W | Data vector, element e at [e*ELEM_W +: ELEM_W] |
| hold_o | output | ELEMS*ELEM_W | Held vector |

## Verification
The data word changes on every clock, so a capture and a data change fall in the same cycle each time an event fires. The check judges whether the word taken is the current one or the one from the clock before, as the previous-cycle mode demands. The first-cycle-after-reset event coincides with leaving the initial condition. It is provoked by holding the trigger high, or low, through reset and checking the word on the following cycle. A change of event select at a steady trigger is also forced, to show that the history update and the select change in the same cycle produce no capture.

// File: rtl/sh_pkg.sv
package sh_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_ANY  = 2'b10,
        EDGE_OFF  = 2'b11
    } edge_sel_e;

    typedef enum logic {
        ST_INIT = 1'b0,
        ST_HELD = 1'b1
    } hold_state_e;
endpackage

// File: rtl/sh_trig_detect.sv
module sh_trig_detect
    import sh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic [1:0] sel_i,
    output logic       event_o,
    output logic       trig_prev_o
);
    logic      trig_q;
    logic      rise_w;
    logic      fall_w;
    edge_sel_e sel_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    assign rise_w = trig_i & ~trig_q;
    assign fall_w = ~trig_i & trig_q;
    assign sel_w  = edge_sel_e'(sel_i);

    always_comb begin
        event_o = 1'b0;
        unique case (sel_w)
            EDGE_RISE: event_o = rise_w;
            EDGE_FALL: event_o = fall_w;
            EDGE_ANY:  event_o = rise_w | fall_w;
            EDGE_OFF:  event_o = 1'b0;
        endcase
    end

    assign trig_prev_o = trig_q;

    // R11
    trig_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> trig_prev_o == $past(trig_i));
endmodule

// File: rtl/sh_prev_data.sv
module sh_prev_data #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/sh_init_vec.sv
module sh_init_vec #(
    parameter int                      ELEMS        = 4,
    parameter int                      ELEM_W       = 8,
    parameter bit                      INIT_BY_ELEM = 1'b1,
    parameter logic [ELEMS*ELEM_W-1:0] INIT_VEC     = '0,
    parameter logic [ELEM_W-1:0]       INIT_SCALAR  = '0
) (
    output logic [ELEMS*ELEM_W-1:0] init_o
);
    generate
        if (INIT_BY_ELEM) begin : g_vec
            assign init_o = INIT_VEC;
        end else begin : g_scalar
            for (genvar e = 0; e < ELEMS; e++) begin : g_elem
                assign init_o[e*ELEM_W +: ELEM_W] = INIT_SCALAR;
            end
        end
    endgenerate
endmodule

// File: rtl/sample_hold_reg.sv
module sample_hold_reg
    import sh_pkg::*;
#(
    parameter int                      ELEMS        = 4,
    parameter int                      ELEM_W       = 8,
    parameter bit                      INIT_BY_ELEM = 1'b1,
    parameter logic [ELEMS*ELEM_W-1:0] INIT_VEC     = '0,
    parameter logic [ELEM_W-1:0]       INIT_SCALAR  = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig_i,
    input  logic [1:0]              edge_sel_i,
    input  logic                    prev_mode_i,
    input  logic [ELEMS*ELEM_W-1:0] data_i,
    output logic [ELEMS*ELEM_W-1:0] hold_o
);
    localparam int DW = ELEMS * ELEM_W;

    hold_state_e   state_q;
    hold_state_e   state_d;
    logic          evt;
    logic          trig_prev;
    logic [DW-1:0] data_prev;
    logic [DW-1:0] init_vec;
    logic [DW-1:0] capture_src;

    sh_trig_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_i),
        .sel_i      (edge_sel_i),
        .event_o    (evt),
        .trig_prev_o(trig_prev)
    );

    sh_prev_data #(.DW(DW)) u_prev (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (data_i),
        .q_o  (data_prev)
    );

    sh_init_vec #(
        .ELEMS       (ELEMS),
        .ELEM_W      (ELEM_W),
        .INIT_BY_ELEM(INIT_BY_ELEM),
        .INIT_VEC    (INIT_VEC),
        .INIT_SCALAR (INIT_SCALAR)
    ) u_init (
        .init_o(init_vec)
    );

    assign capture_src = prev_mode_i ? data_prev : data_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // transitions: first_capture, recapture, wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (evt) state_d = ST_HELD;
            ST_HELD: state_d = ST_HELD;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o <= init_vec;
        end else begin
            unique case (state_q)
                ST_INIT: if (evt) hold_o <= capture_src;
                ST_HELD: if (evt) hold_o <= capture_src;
            endcase
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(hold_o));

    // R8
    capture_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !prev_mode_i) |=> hold_o == $past(data_i));

    // R9
    capture_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && prev_mode_i) |=> hold_o == $past(data_prev));

    // R2
    init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_INIT |-> hold_o == init_vec);

    // R6
    off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_sel_i == 2'b11 |-> !evt);

    // R11
    event_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> trig_i != trig_prev);
endmodule

// File: tb/sample_hold_reg_test.sv
`timescale 1ns/1ps
module sample_hold_reg_test;
    localparam int          N  = 4;
    localparam int          W  = 8;
    localparam logic [31:0] IV = 32'h11223344;
    localparam logic [31:0] SV = 32'h5A5A5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic        lat = 1'b0;
    logic [31:0] data = '0;
    logic [31:0] hold;
    logic [31:0] hold_s;

    int          n_checks = 0;
    int          n_fail = 0;
    logic        m_tp;
    logic [31:0] m_dp;
    logic [31:0] m_exp;
    logic [7:0]  cnt = 8'd0;

    always #2 clk = ~clk;

    sample_hold_reg #(.ELEMS(N), .ELEM_W(W), .INIT_BY_ELEM(1'b1), .INIT_VEC(IV)) uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .edge_sel_i(sel),
        .prev_mode_i(lat), .data_i(data), .hold_o(hold));

    sample_hold_reg #(.ELEMS(N), .ELEM_W(W), .INIT_BY_ELEM(1'b0), .INIT_SCALAR(8'h5A)) uut_s (
        .clk(clk), .rst_n(rst_n), .trig_i(1'b0), .edge_sel_i(2'b00),
        .prev_mode_i(lat), .data_i(data), .hold_o(hold_s));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic t);
        @(negedge clk);
        rst_n = 1'b0;
        trig = t;
        repeat (2) @(negedge clk);
        check("R1", hold, IV);
        rst_n = 1'b1;
        m_tp = 1'b0;
        m_dp = '0;
        m_exp = IV;
    endtask

    function automatic logic [31:0] next_data();
        cnt = cnt + 8'd1;
        return {cnt, ~cnt, cnt + 8'd3, cnt * 8'd5};
    endfunction

    task automatic step(input logic t, input logic [1:0] s, input logic l, input logic [31:0] d);
        logic  rise;
        logic  fall;
        logic  ev;
        string tag;
        trig = t; sel = s; lat = l; data = d;
        rise = t & ~m_tp;
        fall = ~t & m_tp;
        case (s)
            2'b00:   ev = rise;
            2'b01:   ev = fall;
            2'b10:   ev = rise | fall;
            default: ev = 1'b0;
        endcase
        if (ev) begin
            tag = $sformatf("%s %s", (s == 2'b00) ? "R3" : (s == 2'b01) ? "R4" : "R5",
                            l ? "R9" : "R8");
            m_exp = l ? m_dp : d;
        end else begin
            tag = (s == 2'b11) ? "R6" : "R7";
        end
        m_tp = t;
        m_dp = d;
        @(posedge clk);
        @(negedge clk);
        check(tag, hold, m_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        m_tp = 1'b0;
        m_dp = '0;
        m_exp = IV;
        do_reset(1'b0);
        check("R2", hold, IV);
        check("R2", hold_s, SV);

        // sweep: every select, both capture modes, every 4-step trigger pattern
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 2; l++) begin
                for (int p = 0; p < 16; p++) begin
                    for (int b = 0; b < 4; b++) begin
                        step(p[b], s[1:0], l[0], next_data());
                    end
                end
            end
        end
        check("R2", hold_s, SV);

        // R10: trigger high through reset -> rising event on first clock
        do_reset(1'b1);
        step(1'b1, 2'b00, 1'b0, 32'hA1B2C3D4);
        check("R10", hold, 32'hA1B2C3D4);

        // R10: trigger low through reset -> no falling event
        do_reset(1'b0);
        step(1'b0, 2'b01, 1'b0, 32'hDEADBEEF);
        check("R10", hold, IV);

        // R9: previous-cycle mode on first cycle after reset takes zero
        do_reset(1'b0);
        step(1'b1, 2'b00, 1'b1, 32'hCAFEF00D);
        check("R9", hold, 32'h0);

        // R11: rise seen under falling select, then switch to rising at steady trigger
        do_reset(1'b0);
        step(1'b1, 2'b01, 1'b0, 32'h01020304);
        step(1'b1, 2'b00, 1'b0, 32'h05060708);
        check("R11", hold, IV);
        step(1'b1, 2'b10, 1'b0, 32'h090A0B0C);
        check("R11", hold, IV);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule